// File: doc/BRIEF.md
# Read-Modify-Write Shift Unit with Status Flags

This block is the slice of an 8-bit processor that modifies a byte already fetched from memory and prepares it for write-back. It handles a small set of operations: shift left, rotate left, shift right, rotate right, increment and decrement. The block first captures the operand together with the operation code and the incoming carry. It then presents the modified byte on a write port with a one-cycle strobe. Finally it updates the negative, zero and carry status flags.

The flags are not taken from the write-back data as it passes by. The same operation is evaluated again, from the same held operand and carry, on the next active cycle after the write. That second evaluation alone loads the flag registers.

Every register in the block advances only on cycles where the ready input is high. An external memory can therefore stall any phase for any number of cycles. The stored byte and the final flags stay the same whatever the stall pattern. The decimal-mode input is accepted so that the block fits its surroundings, but none of these operations depends on it.

Top module: `rmw_flag_unit`

## Requirements
- R1: After reset, flagN, flagZ and flagC are 0 and wrEn is 0.
- R2: An operation is accepted only on a rising edge where the unit is idle and both start and rdy are high. At that edge the unit captures operand, opSel and carryIn. Later changes to those inputs do not affect the operation. A start seen while rdy is low, or while an operation is in progress, produces no write and no flag change.
- R3: The opSel encoding is as follows. 0 is a left shift that fills with 0. 1 is a left rotate that takes carryIn into bit 0. 2 is a right shift that fills with 0. 3 is a right rotate that takes carryIn into bit 7. 4 adds 1 modulo 256. 5 subtracts 1 modulo 256. 6 and 7 write the operand back unchanged. wrData carries the result in the cycle where wrEn is high.
- R4: wrEn is high for exactly one cycle per accepted operation. That cycle is the first cycle after acceptance in which rdy is high, and wrEn is never high while rdy is low.
- R5: After an operation, flagN equals bit 7 of the byte written. flagZ is 1 exactly when that byte is 0x00. For example, a left rotate of 0x41 with carry clear writes 0x82 and leaves flagN at 1.
- R6: For codes 0 and 1, flagC takes the old bit 7. For codes 2 and 3, flagC takes the old bit 0. For codes 4 to 7, flagC equals the carryIn captured at acceptance.
- R7: While rdy is low, no internal state or flag changes. A low-rdy period of any length, whether before the write cycle or between the write cycle and the flag cycle, leaves the written byte and the final flags unchanged.
- R8: decimalMode has no effect on wrData or on any flag.
- R9: Flags change only on the rising edge of the first active cycle after the write cycle. During and directly after the write cycle they still show their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| rdy | input | 1 | Ready; low stalls every register |
| start | input | 1 | Request to begin an operation |
| opSel | input | 3 | Operation code (see R3) |
| operand | input | DATA_W | Byte fetched from memory |
| carryIn | input | 1 | Current carry flag |
| decimalMode | input | 1 | Current decimal-mode flag (no effect) |
| wrData | output | DATA_W | Modified byte for write-back |
| wrEn | output | 1 | Write strobe, one cycle per operation |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag |

## Verification
The bench builds the unit with DATA_W at 8. At that width every operand value, 0x00 through 0xFF, can be swept under all eight operation codes. This covers the wrap of increment and decrement and the carry moving in and out at both ends of the byte. During the sweep, carry, decimal mode and the stall lengths before the write and before the flag update vary with the operand. Directed runs cover held start, start under a stall, and changes to the inputs after acceptance.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [2:0] {
    OP_SHL  = 3'd0,
    OP_RTL  = 3'd1,
    OP_SHR  = 3'd2,
    OP_RTR  = 3'd3,
    OP_INCR = 3'd4,
    OP_DECR = 3'd5,
    OP_KEEP = 3'd6,
    OP_KEEP2 = 3'd7
  } rmwOp_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WRITE = 2'd1,
    PH_FLAG  = 2'd2
  } rmwPhase_e;

  typedef struct packed {
    logic loadOperand;
    logic writeStrobe;
    logic flagUpdate;
  } rmwCtl_t;

endpackage

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] aIn,
  input  rmwOp_e            op,
  input  logic              cIn,
  output logic [DATA_W-1:0] result,
  output logic              cOut,
  output logic              carryTouched
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    result       = aIn;
    cOut         = cIn;
    carryTouched = 1'b0;
    unique case (op)
      OP_SHL: begin
        result       = {aIn[MSB-1:0], 1'b0};
        cOut         = aIn[MSB];
        carryTouched = 1'b1;
      end
      OP_RTL: begin
        result       = {aIn[MSB-1:0], cIn};
        cOut         = aIn[MSB];
        carryTouched = 1'b1;
      end
      OP_SHR: begin
        result       = {1'b0, aIn[MSB:1]};
        cOut         = aIn[0];
        carryTouched = 1'b1;
      end
      OP_RTR: begin
        result       = {cIn, aIn[MSB:1]};
        cOut         = aIn[0];
        carryTouched = 1'b1;
      end
      OP_INCR: result = aIn + 1'b1;
      OP_DECR: result = aIn - 1'b1;
      default: result = aIn;
    endcase
  end
endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    rdy,
  input  logic    start,
  output rmwCtl_t ctl
);
  rmwPhase_e phase, phaseNext;

  always_comb begin
    ctl.loadOperand = (phase == PH_IDLE)  && rdy && start;
    ctl.writeStrobe = (phase == PH_WRITE) && rdy;
    ctl.flagUpdate  = (phase == PH_FLAG)  && rdy;
  end

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE:  if (start) phaseNext = PH_WRITE;
      PH_WRITE: phaseNext = PH_FLAG;
      PH_FLAG:  phaseNext = PH_IDLE;
      default:  phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    phase <= PH_IDLE;
    else if (rdy) phase <= phaseNext;
  end

  // R7: a stalled cycle leaves the sequencer where it was
  assert_phase_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !rdy |=> $stable(phase));

  // R4: one write strobe per operation, never two in a row
  assert_single_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.writeStrobe |=> !ctl.writeStrobe);

  // R9: the flag phase always directly follows an active write cycle
  assert_flag_after_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.writeStrobe |=> (phase == PH_FLAG));
endmodule

// File: rtl/rmw_datapath.sv
module rmw_datapath
  import rmw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rmwCtl_t           ctl,
  input  logic [DATA_W-1:0] operand,
  input  rmwOp_e            opSel,
  input  logic              carryIn,
  output logic [DATA_W-1:0] wrData,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagC
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] opReg;
  rmwOp_e            opSelReg;
  logic              cinReg;
  logic [DATA_W-1:0] aluRes;
  logic              aluCout;
  logic              aluTouched;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg    <= '0;
      opSelReg <= OP_KEEP;
      cinReg   <= 1'b0;
    end else if (ctl.loadOperand) begin
      opReg    <= operand;
      opSelReg <= opSel;
      cinReg   <= carryIn;
    end
  end

  // One ALU, evaluated on the write cycle and again on the flag cycle
  // from identical held inputs.
  rmw_alu #(.DATA_W(DATA_W)) u_alu (
    .aIn          (opReg),
    .op           (opSelReg),
    .cIn          (cinReg),
    .result       (aluRes),
    .cOut         (aluCout),
    .carryTouched (aluTouched)
  );

  assign wrData = aluRes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagN <= 1'b0;
      flagZ <= 1'b0;
      flagC <= 1'b0;
    end else if (ctl.flagUpdate) begin
      flagN <= aluRes[MSB];
      flagZ <= (aluRes == '0);
      flagC <= aluTouched ? aluCout : cinReg;
    end
  end

  // R7, R9: flags move only on the flag-update strobe from the sequencer
  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.flagUpdate |=> $stable({flagN, flagZ, flagC}));

  // R2: held operand changes only on an accepted start
  assert_operand_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadOperand |=> $stable({opReg, opSelReg, cinReg}));
endmodule

// File: rtl/rmw_flag_unit.sv
module rmw_flag_unit
  import rmw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdy,
  input  logic              start,
  input  logic [2:0]        opSel,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  input  logic              decimalMode,
  output logic [DATA_W-1:0] wrData,
  output logic              wrEn,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagC
);
  localparam int MSB = DATA_W - 1;

  rmwCtl_t ctl;
  logic    unusedDecimal;

  assign unusedDecimal = decimalMode;

  rmw_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .rdy   (rdy),
    .start (start),
    .ctl   (ctl)
  );

  rmw_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .operand (operand),
    .opSel   (rmwOp_e'(opSel)),
    .carryIn (carryIn),
    .wrData  (wrData),
    .flagN   (flagN),
    .flagZ   (flagZ),
    .flagC   (flagC)
  );

  assign wrEn = ctl.writeStrobe;

  // Checking aid: byte actually presented to memory
  logic [DATA_W-1:0] lastWritten;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     lastWritten <= '0;
    else if (wrEn) lastWritten <= wrData;
  end

  // R5: flags agree with the byte that went to memory
  assert_nz_match_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flagUpdate |=> (flagN == lastWritten[MSB]) && (flagZ == (lastWritten == '0)));

  // R4: no write strobe while stalled
  assert_write_needs_rdy_R4: assert property (@(posedge clk) disable iff (!rstN)
    !rdy |-> !wrEn);
endmodule

// File: tb/rmw_flag_unit_bench.sv
`timescale 1ns/1ps
module rmw_flag_unit_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         rdy = 1'b0;
  logic         start = 1'b0;
  logic [2:0]   opSel = '0;
  logic [W-1:0] operand = '0;
  logic         carryIn = 1'b0;
  logic         decimalMode = 1'b0;
  logic [W-1:0] wrData;
  logic         wrEn, flagN, flagZ, flagC;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] wrQ[$];

  always #2.5 clk = ~clk;

  rmw_flag_unit #(.DATA_W(W)) u_rmw_flag_unit (
    .clk(clk), .rstN(rstN), .rdy(rdy), .start(start), .opSel(opSel),
    .operand(operand), .carryIn(carryIn), .decimalMode(decimalMode),
    .wrData(wrData), .wrEn(wrEn), .flagN(flagN), .flagZ(flagZ), .flagC(flagC)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [2:0] op, input logic [W-1:0] a,
                                input logic cin, output logic [W-1:0] res,
                                output logic cout);
    res = a; cout = cin;
    case (op)
      3'd0: begin res = a << 1; cout = a[W-1]; end
      3'd1: begin res = (a << 1) | W'(cin); cout = a[W-1]; end
      3'd2: begin res = a >> 1; cout = a[0]; end
      3'd3: begin res = (a >> 1) | (W'(cin) << (W-1)); cout = a[0]; end
      3'd4: res = a + 1;
      3'd5: res = a - 1;
      default: res = a;
    endcase
  endfunction

  // Monitor: scoreboard of write-back bytes (R3, R4)
  always @(negedge clk) begin
    if (rstN && wrEn) begin
      if (wrQ.size() == 0) check(1'b0, "R4 unexpected write", int'(wrData), 0);
      else begin
        logic [W-1:0] e;
        e = wrQ.pop_front();
        check(wrData == e, "R3 write data", int'(wrData), int'(e));
      end
    end
  end

  task automatic runOp(input logic [2:0] op, input logic [W-1:0] a, input logic cin,
                       input logic dec, input int s0, input int s1,
                       input bit holdStart, input string tag);
    logic [W-1:0] eRes;
    logic eC;
    logic oN, oZ, oC;
    model(op, a, cin, eRes, eC);
    wrQ.push_back(eRes);
    oN = flagN; oZ = flagZ; oC = flagC;
    @(posedge clk); #1;
    start = 1'b1; rdy = 1'b1; opSel = op; operand = a; carryIn = cin; decimalMode = dec;
    @(posedge clk); #1;
    // R2: scramble inputs after acceptance
    start = holdStart; operand = ~a; opSel = op ^ 3'b011; carryIn = ~cin;
    decimalMode = ~dec;
    for (int i = 0; i < s0; i++) begin
      rdy = 1'b0; @(posedge clk); #1;
    end
    rdy = 1'b1; @(posedge clk); #1;
    for (int i = 0; i < s1; i++) begin
      rdy = 1'b0;
      @(negedge clk);
      check({flagN, flagZ, flagC} == {oN, oZ, oC}, "R7/R9 flags held in stall",
            int'({flagN, flagZ, flagC}), int'({oN, oZ, oC}));
      @(posedge clk); #1;
    end
    rdy = 1'b1;
    @(negedge clk);
    check({flagN, flagZ, flagC} == {oN, oZ, oC}, "R9 flags old after write",
          int'({flagN, flagZ, flagC}), int'({oN, oZ, oC}));
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    check(flagN == eRes[W-1] && flagZ == (eRes == 0), {"R5 N/Z ", tag},
          int'({flagN, flagZ}), int'({eRes[W-1], eRes == 0}));
    check(flagC == eC, {"R6 C ", tag}, int'(flagC), int'(eC));
    check(wrQ.size() == 0, {"R4 write count ", tag}, wrQ.size(), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic sN, sZ, sC;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check({flagN, flagZ, flagC, wrEn} == 4'b0, "R1 reset state",
          int'({flagN, flagZ, flagC, wrEn}), 0);

    // Directed cases
    runOp(3'd1, 8'h41, 1'b0, 1'b0, 0, 0, 0, "R5 rotl 41 binary");
    runOp(3'd1, 8'h41, 1'b0, 1'b1, 2, 3, 0, "R8 rotl 41 decimal");
    runOp(3'd0, 8'hC1, 1'b0, 1'b1, 1, 5, 0, "R8 shl decimal");
    runOp(3'd0, 8'h80, 1'b0, 1'b0, 0, 1, 0, "R3 shl to zero");
    runOp(3'd3, 8'h01, 1'b1, 1'b0, 3, 0, 0, "R3 rotr carry in");
    runOp(3'd2, 8'h01, 1'b1, 1'b0, 0, 2, 0, "R3 shr to zero");
    runOp(3'd4, 8'hFF, 1'b1, 1'b0, 1, 1, 0, "R6 incr wrap keeps C");
    runOp(3'd5, 8'h00, 1'b0, 1'b1, 0, 4, 0, "R6 decr wrap keeps C");
    runOp(3'd6, 8'h7F, 1'b1, 1'b0, 0, 0, 0, "R3 keep code 6");
    runOp(3'd2, 8'h83, 1'b0, 1'b0, 2, 2, 1, "R2 start held busy");

    // R2: start while stalled is ignored
    sN = flagN; sZ = flagZ; sC = flagC;
    @(posedge clk); #1;
    start = 1'b1; rdy = 1'b0; operand = 8'h00; opSel = 3'd0;
    @(posedge clk); #1;
    start = 1'b0; rdy = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check({flagN, flagZ, flagC} == {sN, sZ, sC}, "R2 start ignored under stall",
          int'({flagN, flagZ, flagC}), int'({sN, sZ, sC}));

    // Exhaustive sweep, stall lengths and carry/decimal varied
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < 256; a++) begin
        runOp(3'(op), 8'(a), logic'(a[0] ^ op[0]), logic'(a[1]),
              a % 3, (a / 3) % 4, 0, "R7/R8 sweep");
      end
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(wrQ.size() == 0, "R4 no pending writes", wrQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule